// File: doc/BRIEF.md
# Cycle and Event Counting Monitor

This block counts clock cycles and two selectable hardware events for software profiling. A single 32-bit control word holds the master enable, the reset strobes for the counters, the cycle divider, three interrupt enables, three sticky overflow flags and two 8-bit event selectors. Software can clear flags and reconfigure the block in the same write. Each counter is also readable and writable on its own address, so a handler can preload a counter just below its wrap point to take an interrupt after a chosen number of events.

Event sources sit outside the block. They arrive as a 256-bit vector of one-cycle pulses, and each event counter adds one in every enabled cycle in which its selected pulse is high. When the enable bit of a counter is set and that counter wraps, the block raises a single level-sensitive interrupt. The interrupt stays high until software clears the flag or the enable.

Top module: `evmon_top`

## Requirements
- R1: After the synchronous active-high reset, the control word, all three counters, `rd_data` and `irq` are all 0.
- R2: The read data is registered. The value on `rd_data` after a clock edge is the register that `addr` selected before that edge: 0 is the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. A write with `wr_en` high loads the addressed register at the edge.
- R3: Control bit 0 enables all counting. While it is 0, no counter changes except through a direct write or a reset strobe.
- R4: Writing 1 to control bit 1 clears both event counters. Writing 1 to control bit 2 clears the cycle counter and its divider. Both bits read back as 0.
- R5: While control bit 3 is 1, the enabled cycle counter advances exactly once in every 64 clock cycles. While it is 0, the counter advances every cycle.
- R6: Event counter 0 takes its selector from bits 19:12 and event counter 1 from bits 27:20. When enabled, a counter adds one in each cycle in which `evt_in[selector]` is 1.
- R7: A counter whose selector is 0xFF never increments, whatever `evt_in` carries.
- R8: A counter that steps from 0xFFFFFFFF wraps to 0 and sets its overflow flag. The flags sit at bit 8 (event counter 0), bit 9 (event counter 1) and bit 10 (cycle counter).
- R9: Writing 1 to a flag position clears that flag, and writing 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set. A new wrap never clears a pending flag.
- R10: The interrupt enables sit at bit 4 (event counter 0), bit 5 (event counter 1) and bit 6 (cycle counter). `irq` is registered and equals the OR over the counters of flag AND enable, updated at the same edge as the flags and enables.
- R11: Control bits 7, 11 and 31:28 ignore writes and read as 0.
- R12: A direct write to a counter takes priority over that counter's increment in the same cycle, and the increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 2 | Register address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| evt_in | input | 256 | Event pulses, one bit per event code |
| irq | output | 1 | Overflow interrupt, level |

## Verification
A wrong counter value shows on `rd_data` one cycle after the counter's address is read. A wrong flag or enable shows on `irq` at the very edge where the state goes wrong, because `irq` is computed from the next state. The divider is the slowest path: an error in it appears only as a wrong step count over a 64-cycle window. A lost pending flag appears as `irq` dropping without a clearing write.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 8;
  localparam int N_CNT  = 3;

  // control word bit positions (software visible)
  localparam int B_EN      = 0;
  localparam int B_RST_EV  = 1;
  localparam int B_RST_CYC = 2;
  localparam int B_DIV     = 3;
  localparam int B_IEN     = 4;
  localparam int B_FLAG    = 8;
  localparam int B_SEL0    = 12;
  localparam int B_SEL1    = 20;

  // counter index order inside the flag / enable triplets
  localparam int IX_EV0 = 0;
  localparam int IX_EV1 = 1;
  localparam int IX_CYC = 2;

  localparam logic [SEL_W-1:0] SEL_NONE = '1;

  typedef enum logic [1:0] {
    RA_CTL = 2'd0,
    RA_CYC = 2'd1,
    RA_EV0 = 2'd2,
    RA_EV1 = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/evmon_prescale.sv
module evmon_prescale #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic tick
);
  logic [DIV_LOG2-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr || !run) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (&cnt_q);
endmodule

// File: rtl/evmon_counter.sv
module evmon_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] value,
  output logic             wrap
);
  logic [CNT_W-1:0] val_q;

  assign wrap  = inc && !wr && !clr && (&val_q);
  assign value = val_q;

  always_ff @(posedge clk) begin
    if (rst)      val_q <= '0;
    else if (wr)  val_q <= wdata;
    else if (clr) val_q <= '0;
    else if (inc) val_q <= val_q + 1'b1;
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (val_q == '0)); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr |=> (val_q == $past(wdata))); // R12
endmodule

// File: rtl/evmon_ctrl.sv
module evmon_ctrl
  import evmon_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                ctl_wr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [N_CNT-1:0]    wrap,
  output logic                en,
  output logic                div,
  output logic [N_CNT-1:0]    ien,
  output logic [N_CNT-1:0]    flags,
  output logic [SEL_W-1:0]    sel0,
  output logic [SEL_W-1:0]    sel1,
  output logic                rst_ev,
  output logic                rst_cyc,
  output logic                irq
);
  logic                en_q, div_q, irq_q;
  logic [N_CNT-1:0]    ien_q, flag_q, clr_vec, flag_d, ien_d;
  logic [SEL_W-1:0]    sel0_q, sel1_q;

  assign clr_vec = ctl_wr ? wdata[B_FLAG +: N_CNT] : '0;
  assign flag_d  = (flag_q & ~clr_vec) | wrap;
  assign ien_d   = ctl_wr ? wdata[B_IEN +: N_CNT] : ien_q;
  assign rst_ev  = ctl_wr && wdata[B_RST_EV];
  assign rst_cyc = ctl_wr && wdata[B_RST_CYC];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      div_q  <= 1'b0;
      ien_q  <= '0;
      flag_q <= '0;
      sel0_q <= '0;
      sel1_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ien_q  <= ien_d;
      irq_q  <= |(flag_d & ien_d);
      if (ctl_wr) begin
        en_q   <= wdata[B_EN];
        div_q  <= wdata[B_DIV];
        sel0_q <= wdata[B_SEL0 +: SEL_W];
        sel1_q <= wdata[B_SEL1 +: SEL_W];
      end
    end
  end

  assign en    = en_q;
  assign div   = div_q;
  assign ien   = ien_q;
  assign flags = flag_q;
  assign sel0  = sel0_q;
  assign sel1  = sel1_q;
  assign irq   = irq_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((flag_q & ~clr_vec) != '0) |=> ((flag_q & $past(flag_q & ~clr_vec)) == $past(flag_q & ~clr_vec))); // R9
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    ((|(wrap & ien_q)) && !ctl_wr) |=> irq_q); // R10
endmodule

// File: rtl/evmon_top.sv
module evmon_top
  import evmon_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int DIV_LOG2 = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [1:0]            addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [(1<<SEL_W)-1:0] evt_in,
  output logic                  irq
);
  localparam int N_EVT = 1 << SEL_W;

  logic              en, div, rst_ev, rst_cyc, tick, ctl_wr;
  logic [N_CNT-1:0]  ien, flags, wrap, cnt_wr, cnt_clr, cnt_inc;
  logic [SEL_W-1:0]  sel0, sel1;
  logic [CNT_W-1:0]  cnt_val [N_CNT];
  logic [DATA_W-1:0] ctl_word, rd_q;

  assign ctl_wr = wr_en && (addr == RA_CTL);

  evmon_ctrl u_ctrl (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .wdata(wr_data), .wrap(wrap),
    .en(en), .div(div), .ien(ien), .flags(flags), .sel0(sel0), .sel1(sel1),
    .rst_ev(rst_ev), .rst_cyc(rst_cyc), .irq(irq)
  );

  evmon_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk(clk), .rst(rst), .run(en && div), .clr(rst_cyc), .tick(tick)
  );

  // event counters share one structure; only the selector differs
  for (genvar g = 0; g < 2; g++) begin : g_ev
    logic [SEL_W-1:0] sel;
    assign sel        = (g == 0) ? sel0 : sel1;
    assign cnt_wr[g]  = wr_en && (addr == ((g == 0) ? RA_EV0 : RA_EV1));
    assign cnt_clr[g] = rst_ev;
    assign cnt_inc[g] = en && (sel != SEL_NONE) && evt_in[sel];

    evmon_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .wr(cnt_wr[g]), .wdata(wr_data[CNT_W-1:0]),
      .clr(cnt_clr[g]), .inc(cnt_inc[g]), .value(cnt_val[g]), .wrap(wrap[g])
    );

    AST_UNUSED_IDLE: assert property (@(posedge clk) disable iff (rst)
      ((sel == SEL_NONE) && !cnt_wr[g] && !cnt_clr[g]) |=> $stable(cnt_val[g])); // R7
  end

  assign cnt_wr[IX_CYC]  = wr_en && (addr == RA_CYC);
  assign cnt_clr[IX_CYC] = rst_cyc;
  assign cnt_inc[IX_CYC] = en && (!div || tick);

  evmon_counter #(.CNT_W(CNT_W)) u_cyc (
    .clk(clk), .rst(rst), .wr(cnt_wr[IX_CYC]), .wdata(wr_data[CNT_W-1:0]),
    .clr(cnt_clr[IX_CYC]), .inc(cnt_inc[IX_CYC]), .value(cnt_val[IX_CYC]),
    .wrap(wrap[IX_CYC])
  );

  always_comb begin
    ctl_word                      = '0;
    ctl_word[B_EN]                = en;
    ctl_word[B_DIV]               = div;
    ctl_word[B_IEN +: N_CNT]      = ien;
    ctl_word[B_FLAG +: N_CNT]     = flags;
    ctl_word[B_SEL0 +: SEL_W]     = sel0;
    ctl_word[B_SEL1 +: SEL_W]     = sel1;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      unique case (reg_addr_e'(addr))
        RA_CTL: rd_q <= ctl_word;
        RA_CYC: rd_q <= DATA_W'(cnt_val[IX_CYC]);
        RA_EV0: rd_q <= DATA_W'(cnt_val[IX_EV0]);
        RA_EV1: rd_q <= DATA_W'(cnt_val[IX_EV1]);
        default: rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && div && !tick && !cnt_wr[IX_CYC] && !rst_cyc) |=> $stable(cnt_val[IX_CYC])); // R5
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_en) |=> ($stable(cnt_val[IX_CYC]) && $stable(cnt_val[IX_EV0]))); // R3

  initial begin
    AST_EVT_WIDTH: assert (N_EVT == 256); // R6
  end
endmodule

// File: tb/evmon_top_tb_top.sv
module evmon_top_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         wr_en;
  logic [1:0]   addr;
  logic [31:0]  wr_data;
  logic [31:0]  rd_data;
  logic [255:0] evt_in;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  evmon_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .evt_in(evt_in), .irq(irq)
  );

  // reference model state
  logic        m_en, m_div, m_irq;
  logic [2:0]  m_ien, m_flag;
  logic [7:0]  m_sel0, m_sel1;
  logic [31:0] m_cyc, m_c0, m_c1;
  logic [5:0]  m_pre;

  function automatic logic [31:0] m_ctl_word();
    logic [31:0] w = '0;
    w[0] = m_en; w[3] = m_div; w[6:4] = m_ien; w[10:8] = m_flag;
    w[19:12] = m_sel0; w[27:20] = m_sel1;
    return w;
  endfunction

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_ctl_word();
      2'd1: return m_cyc;
      2'd2: return m_c0;
      default: return m_c1;
    endcase
  endfunction

  task automatic m_reset();
    m_en = 0; m_div = 0; m_irq = 0; m_ien = 0; m_flag = 0;
    m_sel0 = 0; m_sel1 = 0; m_cyc = 0; m_c0 = 0; m_c1 = 0; m_pre = 0;
  endtask

  task automatic m_step(input logic w, input logic [1:0] a, input logic [31:0] d,
                        input logic [255:0] ev);
    logic        cw, tick, i0, i1, ic;
    logic [2:0]  wr3, clr;
    logic [32:0] s;
    cw   = w && a == 2'd0;
    tick = m_en && (!m_div || m_pre == 6'd63);
    i0   = m_en && m_sel0 != 8'hFF && ev[m_sel0];
    i1   = m_en && m_sel1 != 8'hFF && ev[m_sel1];
    ic   = tick;
    wr3  = 0;
    clr  = cw ? d[10:8] : 3'b0;
    if (w && a == 2'd2) m_c0 = d;
    else if (cw && d[1]) m_c0 = 0;
    else if (i0) begin s = {1'b0, m_c0} + 33'd1; m_c0 = s[31:0]; wr3[0] = s[32]; end
    if (w && a == 2'd3) m_c1 = d;
    else if (cw && d[1]) m_c1 = 0;
    else if (i1) begin s = {1'b0, m_c1} + 33'd1; m_c1 = s[31:0]; wr3[1] = s[32]; end
    if (w && a == 2'd1) m_cyc = d;
    else if (cw && d[2]) m_cyc = 0;
    else if (ic) begin s = {1'b0, m_cyc} + 33'd1; m_cyc = s[31:0]; wr3[2] = s[32]; end
    if ((cw && d[2]) || !(m_en && m_div)) m_pre = 0; else m_pre = m_pre + 6'd1;
    m_flag = (m_flag & ~clr) | wr3;
    if (cw) begin
      m_en = d[0]; m_div = d[3]; m_ien = d[6:4]; m_sel0 = d[19:12]; m_sel1 = d[27:20];
    end
    m_irq = |(m_flag & m_ien);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare after the edge against the model
  task automatic cyc(input string tag, input logic w, input logic [1:0] a,
                     input logic [31:0] d, input logic [255:0] ev);
    logic [31:0] exp_rd;
    wr_en = w; addr = a; wr_data = d; evt_in = ev;
    exp_rd = m_read(a);
    m_step(w, a, d, ev);
    @(posedge clk); #2;
    chk({tag, " R2 rd"}, rd_data, exp_rd);
    chk({tag, " R10 irq"}, {31'b0, irq}, {31'b0, m_irq});
    @(negedge clk);
  endtask

  localparam logic [255:0] EV5  = 256'd1 << 5;
  localparam logic [255:0] EVALL = '1;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v1, v2;
    void'($urandom(32'd20240607));
    rst = 1; wr_en = 0; addr = 0; wr_data = 0; evt_in = 0;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk("R1 rd after reset", rd_data, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    for (int a = 0; a < 4; a++) begin
      cyc("R1", 0, 2'(a), 0, 0);
      chk("R1 reg zero", rd_data, 32'h0);
    end

    // configure: enable, sel0=5, sel1=unused, all interrupt enables, reserved bits set
    cyc("R11 cfg", 1, 0, 32'hFFF058F1, 0);
    repeat (3) cyc("R6 count", 0, 2, 0, EVALL);
    cyc("R6", 0, 2, 0, 0);
    chk("R6 c0 counted selected pulses", rd_data, 32'd3);
    cyc("R7", 0, 3, 0, 0);
    chk("R7 c1 with sel 0xFF", rd_data, 32'd0);
    cyc("R11", 0, 0, 0, 0);
    chk("R11 reserved bits read zero", rd_data, 32'h0FF05071);

    // write beats increment, then wrap
    cyc("R12 wr", 1, 2, 32'hFFFFFFFF, EVALL);
    cyc("R12", 0, 2, 0, 0);
    chk("R12 write over increment", rd_data, 32'hFFFFFFFF);
    cyc("R8 wrap", 0, 0, 0, EV5);
    chk("R10 irq on enabled wrap", {31'b0, irq}, 32'd1);
    cyc("R8", 0, 0, 0, 0);
    chk("R8 flag bit8 set", rd_data, 32'h0FF05171);
    cyc("R8", 0, 2, 0, 0);
    chk("R8 wrapped to zero", rd_data, 32'h0);

    // clear collides with a new wrap: flag must stay
    cyc("R9 wr", 1, 2, 32'hFFFFFFFF, 0);
    cyc("R9 clr+wrap", 1, 0, 32'h0FF05171, EV5);
    cyc("R9", 0, 0, 0, 0);
    chk("R9 set wins over clear", rd_data, 32'h0FF05171);
    cyc("R9 clr", 1, 0, 32'h0FF05171, 0);
    cyc("R9", 0, 0, 0, 0);
    chk("R9 flag cleared by W1C", rd_data, 32'h0FF05071);
    chk("R10 irq low after clear", {31'b0, irq}, 32'd0);

    // pending flag with interrupt disabled, then enabled
    cyc("R10 cfg", 1, 0, 32'h0FF05001, 0);
    cyc("R10 wr", 1, 2, 32'hFFFFFFFF, 0);
    cyc("R10 wrap", 0, 0, 0, EV5);
    chk("R10 irq masked", {31'b0, irq}, 32'd0);
    cyc("R10", 0, 0, 0, 0);
    chk("R10 flag pending while masked", rd_data, 32'h0FF05101);
    cyc("R10 ien", 1, 0, 32'h0FF05011, 0);
    chk("R10 irq after enabling", {31'b0, irq}, 32'd1);

    // reset strobes
    cyc("R4 wr", 1, 2, 32'h1234, 0);
    cyc("R4 wr", 1, 1, 32'h5678, 0);
    cyc("R4 strobe", 1, 0, 32'h0FF05017, 0);
    cyc("R4", 0, 2, 0, 0);
    chk("R4 event counter cleared", rd_data, 32'h0);
    cyc("R4", 0, 0, 0, 0);
    chk("R4 strobe bits read zero", rd_data, 32'h0FF05111);

    // disabled: counters hold
    cyc("R3 off", 1, 0, 32'h0FF05010, 0);
    cyc("R3", 0, 1, 0, EVALL);
    v1 = rd_data;
    repeat (5) cyc("R3", 0, 1, 0, EVALL);
    chk("R3 cycle counter held while disabled", rd_data, v1);
    cyc("R3", 0, 2, 0, 0);
    chk("R3 event counter held while disabled", rd_data, 32'h0);

    // divider
    cyc("R5 cfg", 1, 0, 32'h0FF0500D, 0);
    repeat (10) cyc("R5", 0, 1, 0, 0);
    v1 = rd_data;
    repeat (64) cyc("R5", 0, 1, 0, 0);
    v2 = rd_data;
    chk("R5 one step per 64 cycles", v2 - v1, 32'd1);
    cyc("R5 nodiv", 1, 0, 32'h0FF05001, 0);
    cyc("R5", 0, 1, 0, 0);
    v1 = rd_data;
    repeat (8) cyc("R5", 0, 1, 0, 0);
    chk("R5 every cycle without divider", rd_data - v1, 32'd8);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [255:0] ev;
      logic [31:0]  d;
      logic [1:0]   a;
      logic         w;
      int           r;
      for (int k = 0; k < 8; k++) ev[k*32 +: 32] = $urandom & $urandom & $urandom;
      a = 2'($urandom);
      r = $urandom % 16;
      w = (r < 3);
      d = $urandom;
      if (a == 2'd0) begin
        d[0] = ($urandom % 6) != 0;
        d[1] = ($urandom % 8) == 0;
        d[2] = ($urandom % 8) == 0;
        r = $urandom % 4;
        d[19:12] = (r == 0) ? 8'hFF : (r == 1) ? 8'd5 : 8'($urandom);
        r = $urandom % 4;
        d[27:20] = (r == 0) ? 8'hFF : (r == 1) ? 8'd200 : 8'($urandom);
      end else begin
        d = 32'hFFFFFFF0 | 32'($urandom % 16);
      end
      cyc("RND R6 R8 R9 R12", w, a, d, ev);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule